// File: doc/BRIEF.md
# Rotating Resistor-Loop Flash ADC Controller

This block is the digital sequencer and decoder for a flash converter whose reference ladder is a closed ring of resistive elements. Each conversion runs through P passes. In every pass the ring is opened at a different node, which turns it into a resistor string between the two references. The comparators are read, and the result of each pass is turned into a code using the cumulative element weights of that pass's string. The P codes are summed and the sum is divided by P. This averages out element mismatch, because each code value is produced by P different sets of resistors.

Elements may be merged resistors of integer weight. The element weights are a parameter whose total is 2^K. All switch controls come from registered state, so they change only at a clock edge. Host logic starts a conversion with `start`, sees `busy` for P cycles, and takes the averaged code when `done` pulses.

Top module: `rl_ladder_ctrl`

## Requirements
- R1: Synchronous reset puts the block in idle with busy, done and result at 0, and every loop switch and tap switch open (all control bits 0).
- R2: A start seen in idle makes busy rise at the next edge. Busy then stays high for exactly P cycles.
- R3: During pass j (j = 0 for the first busy cycle), loop-switch control bit j is 0 (open) and every other loop-switch bit is 1 (closed).
- R4: During pass j, only bit j of the negative-tap control and only bit j of the positive-tap control are 1. Node j lies between element j-1 (positive side) and element j (negative side).
- R5: In pass j, comparator bit i watches node i. The pass code is the sum of element weights from element j up to the highest node whose comparator bit is 1, counted in ring order from node j+1. The code is 0 if no bit is 1.
- R6: In the cycle after the last pass, done is high for exactly one cycle, busy is low, and result equals the sum of the P codes shifted right by log2(P).
- R7: Result holds its value in every cycle in which done is low.
- R8: Start while busy is ignored. The conversion in flight is neither restarted nor lengthened.
- R9: Between conversions, every switch control bit is 0.
- R10: Start asserted during the done cycle is accepted, and the next conversion begins at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request |
| cmp_bits | input | N | Comparator outputs, bit i at ring node i |
| busy | output | 1 | Passes in progress |
| done | output | 1 | One-cycle pulse when result updates |
| result | output | K | Averaged conversion code |
| loop_close | output | N | Ring switch controls, 1 = closed |
| neg_tap | output | N | Negative reference tap controls, 1 = closed |
| pos_tap | output | N | Positive reference tap controls, 1 = closed |

## Verification
The hardest case is making the per-pass code depend on the break position. This only happens if the comparator vector changes with the switch state inside one conversion. The bench therefore uses a behavioural ring model. It reads the live tap controls, finds the broken node, and compares a fixed analog level against the cumulative weights of that string. It runs with non-uniform weights, so the codes of different passes differ, and the table values are chosen so that truncation of the averaged sum shows up.

// File: rtl/rl_ladder_pkg.sv
package rl_ladder_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } rl_phase_e;
endpackage

// File: rtl/rl_switch_drive.sv
module rl_switch_drive #(
    parameter int N     = 6,
    parameter int P     = 4,
    parameter int CFG_W = 2
) (
    input  logic             active,
    input  logic [CFG_W-1:0] cfg,
    output logic [N-1:0]     loop_close,
    output logic [N-1:0]     neg_tap,
    output logic [N-1:0]     pos_tap
);
    // Node i can only be the break point when i < P.
    for (genvar i = 0; i < N; i++) begin : g_node
        logic open_here;
        if (i < P) begin : g_brk
            assign open_here = active && (cfg == CFG_W'(i));
        end else begin : g_fixed
            assign open_here = 1'b0;
        end
        assign loop_close[i] = active && !open_here;
        assign neg_tap[i]    = open_here;
        assign pos_tap[i]    = open_here;
    end
endmodule

// File: rtl/rl_pass_decoder.sv
module rl_pass_decoder #(
    parameter int              K       = 3,
    parameter int              N       = 6,
    parameter int              P       = 4,
    parameter int              WW      = 4,
    parameter logic [N*WW-1:0] WEIGHTS = 24'h121211,
    parameter int              CFG_W   = 2,
    parameter int              CODE_W  = 4
) (
    input  logic [N-1:0]      cmp,
    input  logic [CFG_W-1:0]  cfg,
    output logic [CODE_W-1:0] code
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    // Weight from element c up to (not including) element c+m, ring order.
    function automatic int cum(input int c, input int m);
        int s = 0;
        for (int i = 0; i < m; i++) begin
            s += int'(WEIGHTS[((c + i) % N) * WW +: WW]);
        end
        return s;
    endfunction

    logic [CODE_W-1:0] code_tab [P];

    for (genvar c = 0; c < P; c++) begin : g_cfg
        always_comb begin
            code_tab[c] = '0;
            for (int m = 1; m < N; m++) begin
                if (cmp[IDX_W'((c + m) % N)]) begin
                    code_tab[c] = CODE_W'(cum(c, m));
                end
            end
        end
    end

    assign code = code_tab[cfg];
endmodule

// File: rtl/rl_ladder_ctrl.sv
module rl_ladder_ctrl
    import rl_ladder_pkg::*;
#(
    parameter int              K       = 3,
    parameter int              N       = 6,
    parameter int              P       = 4,
    parameter int              WW      = 4,
    parameter logic [N*WW-1:0] WEIGHTS = 24'h121211
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] cmp_bits,
    output logic         busy,
    output logic         done,
    output logic [K-1:0] result,
    output logic [N-1:0] loop_close,
    output logic [N-1:0] neg_tap,
    output logic [N-1:0] pos_tap
);
    localparam int LOGP   = $clog2(P);
    localparam int CFG_W  = (LOGP > 0) ? LOGP : 1;
    localparam int CODE_W = K + 1;
    localparam int ACC_W  = K + LOGP + 1;

    typedef struct packed {
        rl_phase_e        phase;
        logic [CFG_W-1:0] cfg;
        logic [ACC_W-1:0] acc;
        logic [K-1:0]     result;
        logic             done;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic [CODE_W-1:0]  pass_code;
    logic [ACC_W-1:0]   acc_sum;

    rl_pass_decoder #(
        .K(K), .N(N), .P(P), .WW(WW), .WEIGHTS(WEIGHTS),
        .CFG_W(CFG_W), .CODE_W(CODE_W)
    ) u_dec (
        .cmp  (cmp_bits),
        .cfg  (st_q.cfg),
        .code (pass_code)
    );

    rl_switch_drive #(.N(N), .P(P), .CFG_W(CFG_W)) u_sw (
        .active     (st_q.phase == PH_RUN),
        .cfg        (st_q.cfg),
        .loop_close (loop_close),
        .neg_tap    (neg_tap),
        .pos_tap    (pos_tap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        acc_sum   = st_q.acc + ACC_W'(pass_code);
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cfg   = '0;
                    st_d.acc   = '0;
                end
            end
            PH_RUN: begin
                if (st_q.cfg == CFG_W'(P - 1)) begin
                    st_d.phase  = PH_IDLE;
                    st_d.cfg    = '0;
                    st_d.result = K'(acc_sum >> LOGP);
                    st_d.done   = 1'b1;
                end else begin
                    st_d.cfg = st_q.cfg + 1'b1;
                    st_d.acc = acc_sum;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, cfg: '0, acc: '0, result: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.phase == PH_RUN);
    assign done   = st_q.done;
    assign result = st_q.result;

    // R2, R8: a pass that is not the last is always followed by another busy cycle
    assert_no_early_end_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && st_q.cfg != CFG_W'(P - 1)) |=> busy);
    // R3: exactly one ring switch open while busy
    assert_single_break_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(~loop_close) == 1));
    // R4: tap pair sits at the open ring node
    assert_taps_at_break_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (neg_tap == ~loop_close && pos_tap == (N'(1) << st_q.cfg)));
    // R6: done lasts one cycle and follows a busy cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    // R7: result moves only with done
    assert_hold_result_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
    // R9: idle leaves every switch open
    assert_idle_open_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (loop_close == '0 && neg_tap == '0 && pos_tap == '0));
endmodule

// File: tb/rl_ladder_ctrl_tb.sv
module rl_ladder_ctrl_tb_top;
    localparam int              K  = 3;
    localparam int              N  = 6;
    localparam int              P  = 4;
    localparam int              WW = 4;
    localparam logic [N*WW-1:0] WT = 24'h121211;
    localparam int              NV = 9;
    // analog level in half-LSB units, expected averaged code
    localparam int VEC_VIN [NV] = '{0, 3, 5, 7, 9, 11, 13, 15, 17};
    localparam int VEC_EXP [NV] = '{0, 0, 1, 2, 3, 4, 5, 6, 6};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] cmp_bits;
    logic         busy, done;
    logic [K-1:0] result;
    logic [N-1:0] loop_close, neg_tap, pos_tap;
    int           vin_h = 0;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    always #2.5ns clk = ~clk;

    rl_ladder_ctrl #(.K(K), .N(N), .P(P), .WW(WW), .WEIGHTS(WT)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cmp_bits(cmp_bits),
        .busy(busy), .done(done), .result(result),
        .loop_close(loop_close), .neg_tap(neg_tap), .pos_tap(pos_tap)
    );

    // Behavioural ring: string starts at the element on the negative tap side.
    function automatic logic [N-1:0] ladder(input logic [N-1:0] ntap, input int v);
        logic [N-1:0] r = '0;
        int brk = -1;
        int s;
        for (int i = 0; i < N; i++) if (ntap[i]) brk = i;
        if (brk >= 0) begin
            s = 0;
            for (int m = 1; m < N; m++) begin
                s += int'(WT[((brk + m - 1) % N) * WW +: WW]);
                r[(brk + m) % N] = (v > 2 * s);
            end
        end
        return r;
    endfunction

    always_comb cmp_bits = ladder(neg_tap, vin_h);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_pass(input int j);
        check(busy == 1'b1, "R2 busy in pass", int'(busy), 1);
        check(loop_close == ~(N'(1) << j), "R3 loop switches", int'(loop_close),
              int'(~(N'(1) << j)));
        check(neg_tap == (N'(1) << j) && pos_tap == (N'(1) << j), "R4 taps",
              int'({neg_tap, pos_tap}), int'({N'(1) << j, N'(1) << j}));
    endtask

    task automatic check_idle(input string tag);
        check(loop_close == '0 && neg_tap == '0 && pos_tap == '0, tag,
              int'({loop_close, neg_tap, pos_tap}), 0);
    endtask

    // start sampled at the next edge; returns in the done cycle
    task automatic run_passes(input bit hold_start);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = hold_start;
        for (int j = 0; j < P; j++) begin
            check_pass(j);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 reset outputs",
              int'({busy, done, result}), 0);
        check_idle("R1 reset switches");
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R5, R6, R7, R9
        for (int v = 0; v < NV; v++) begin
            vin_h = VEC_VIN[v];
            run_passes(1'b0);
            check(done == 1'b1 && busy == 1'b0, "R6 done cycle", int'({done, busy}), 2);
            check(int'(result) == VEC_EXP[v], "R5 averaged code", int'(result), VEC_EXP[v]);
            @(negedge clk);
            check(done == 1'b0, "R6 done one cycle", int'(done), 0);
            check(int'(result) == VEC_EXP[v], "R7 result held", int'(result), VEC_EXP[v]);
            check_idle("R9 idle switches");
        end

        // R8, R10: start held high through a conversion and its done cycle
        vin_h = 9;
        run_passes(1'b1);
        check(done == 1'b1 && busy == 1'b0, "R8 no restart or stretch", int'({done, busy}), 2);
        check(int'(result) == 3, "R8 result", int'(result), 3);
        @(negedge clk); start = 1'b0;
        check(done == 1'b0, "R10 done dropped", int'(done), 0);
        for (int j = 0; j < P; j++) begin
            check_pass(j);
            @(negedge clk);
        end
        check(done == 1'b1 && int'(result) == 3, "R10 back-to-back conversion",
              int'({done, result}), 11);

        // R7: change level while idle, result must not move
        vin_h = 17;
        repeat (3) @(negedge clk);
        check(int'(result) == 3, "R7 idle hold", int'(result), 3);

        // R1: reset in mid conversion
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 mid reset",
              int'({busy, done, result}), 0);
        check_idle("R1 mid reset switches");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule